// File: doc/BRIEF.md
# Configurable Shift and Rotate Unit

This block performs the shift work of a RISC execute stage on a 32-bit operand. It supports three operation kinds: logical shift, arithmetic shift and rotate. Each kind can run left or right. The unit is started with a one-cycle strobe. The shift distance comes either from a small immediate field or from the low bits of a register operand.

Each operation kind has its own elaboration parameter, and that parameter picks one of three builds:

- **None.** Nothing is built for the kind. Requests for it are flagged as unimplemented so that software can emulate them.
- **Serial.** The kind moves the data one bit position per clock. The unit reports busy while it works.
- **Barrel.** The kind finishes any distance in one clock.

Because each kind is chosen separately, latency and area can differ between kinds inside one unit. The unit does not stall anything itself. It only reports busy, and the surrounding pipeline uses that signal.

Top module: `shift_unit`

## Requirements
- R1: `op_kind` encodes 0 as logical shift, 1 as arithmetic shift, 2 as rotate and 3 as reserved. `dir_left`=1 shifts toward the MSB. A logical shift fills vacated bits with 0. An arithmetic right shift fills them with copies of bit 31, and an arithmetic left shift fills them with 0. A rotate moves each bit that leaves one end into the other end.
- R2: When `amt_from_imm`=1 the distance is `imm_amt`. Otherwise it is `reg_amt[4:0]`, and bits 31:5 of `reg_amt` have no effect.
- R3: For a kind built as barrel, an accepted start gives `done`=1 and the new `result` in the next cycle, and `busy` stays 0.
- R4: For a kind built as serial with distance N>0, `busy` is 1 for the N cycles after the accepting edge. `done` and the final `result` appear in the cycle where `busy` returns to 0.
- R5: For a kind built as serial with distance 0, `done` is 1 in the next cycle, `busy` stays 0, and `result` equals the operand.
- R6: For a kind built as none, and for kind 3, `unimpl` is 1 in the next cycle, `done` stays 0, and `result` keeps its previous value.
- R7: A start that arrives while `busy`=1 is ignored. The running operation finishes with its own result and latency.
- R8: `done` and `unimpl` are single-cycle pulses, one per accepted start, and are never 1 together.
- R9: After reset, `result` is 0 and `busy`, `done` and `unimpl` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| op_kind | input | 2 | Operation kind select |
| dir_left | input | 1 | 1 = shift toward MSB, 0 = toward LSB |
| amt_from_imm | input | 1 | 1 = take distance from `imm_amt` |
| imm_amt | input | 5 | Immediate shift distance |
| reg_amt | input | 32 | Register operand carrying the distance in its low bits |
| operand | input | 32 | Data to shift |
| result | output | 32 | Registered result |
| busy | output | 1 | Serial operation in progress |
| done | output | 1 | Result updated this cycle |
| unimpl | output | 1 | Requested kind is not built in hardware |

## Verification
Counting from the edge that samples `start`, barrel results, zero-distance serial results and the unimplemented flag are due right after that edge. A serial result with distance N is due N edges later, and `busy` covers exactly the cycles in between. The bench samples on falling edges, walks a fixed 40-cycle window after every start, and records the cycle of the first `done` or `unimpl` and how many of each occurred. It then compares that cycle with the latency the requirements give for the parameter set of each of the two instances it drives.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {IMPL_NONE = 2'd0, IMPL_SERIAL = 2'd1, IMPL_BARREL = 2'd2} impl_e;
  typedef enum logic [1:0] {OP_LSH = 2'd0, OP_ASH = 2'd1, OP_ROT = 2'd2, OP_RSV = 2'd3} op_e;
endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic             from_imm,
  input  logic [AMT_W-1:0] imm,
  input  logic [W-1:0]     reg_val,
  output logic [AMT_W-1:0] amt
);
  // Only the low bits of the register select the distance (R2).
  logic unused_reg_hi;
  assign unused_reg_hi = ^reg_val[W-1:AMT_W];
  assign amt = from_imm ? imm : reg_val[AMT_W-1:0];
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel import shift_pkg::*; #(
  parameter int  W     = 32,
  parameter op_e KIND  = OP_LSH,
  parameter int  AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  input  logic             left,
  output logic [W-1:0]     dout
);
  function automatic logic [W-1:0] by_const(input logic [W-1:0] d, input int n, input logic l);
    logic signed [W-1:0] ds;
    ds = d;
    if (KIND == OP_ROT)
      return l ? ((d << n) | (d >> (W - n))) : ((d >> n) | (d << (W - n)));
    else if (KIND == OP_ASH && !l)
      return ds >>> n;
    else
      return l ? (d << n) : (d >> n);
  endfunction

  logic [W-1:0] stage [AMT_W+1];
  assign stage[0] = din;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int BY = 1 << s;
    assign stage[s+1] = amt[s] ? by_const(stage[s], BY, left) : stage[s];
  end

  assign dout = stage[AMT_W];
endmodule

// File: rtl/shift_serial.sv
module shift_serial import shift_pkg::*; #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  op_e              load_kind,
  input  logic             load_left,
  input  logic [W-1:0]     load_data,
  input  logic [AMT_W-1:0] load_amt,
  output logic             busy,
  output logic             last,
  output logic [W-1:0]     next_data
);
  logic [W-1:0]     work;
  logic [AMT_W-1:0] cnt;
  op_e              kind_q;
  logic             left_q;

  always_comb begin
    unique case (kind_q)
      OP_ROT:  next_data = left_q ? {work[W-2:0], work[W-1]} : {work[0], work[W-1:1]};
      OP_ASH:  next_data = left_q ? {work[W-2:0], 1'b0} : {work[W-1], work[W-1:1]};
      default: next_data = left_q ? {work[W-2:0], 1'b0} : {1'b0, work[W-1:1]};
    endcase
  end

  assign last = busy && (cnt == AMT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      work   <= '0;
      kind_q <= OP_LSH;
      left_q <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      cnt    <= load_amt;
      work   <= load_data;
      kind_q <= load_kind;
      left_q <= load_left;
    end else if (busy) begin
      work <= next_data;
      cnt  <= cnt - AMT_W'(1);
      if (cnt == AMT_W'(1)) busy <= 1'b0;
    end
  end

  // R4: a running operation always has steps left and counts down by one.
  a_r4_cnt_live: assert property (@(posedge clk) disable iff (rst) busy |-> cnt != '0);
  a_r4_countdown: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && cnt == $past(cnt) - AMT_W'(1)));
  // R7: the engine is never reloaded mid-run.
  a_r7_no_reload: assert property (@(posedge clk) disable iff (rst) busy |-> !load);
endmodule

// File: rtl/shift_unit.sv
module shift_unit import shift_pkg::*; #(
  parameter int    DATA_W   = 32,
  parameter impl_e LSH_IMPL = IMPL_BARREL,
  parameter impl_e ASH_IMPL = IMPL_SERIAL,
  parameter impl_e ROT_IMPL = IMPL_SERIAL,
  localparam int   AMT_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op_kind,
  input  logic              dir_left,
  input  logic              amt_from_imm,
  input  logic [AMT_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] reg_amt,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              busy,
  output logic              done,
  output logic              unimpl
);
  localparam int    NKIND = 3;
  localparam impl_e IMPLS [NKIND] = '{LSH_IMPL, ASH_IMPL, ROT_IMPL};

  op_e              kind;
  impl_e            cur_impl;
  logic [AMT_W-1:0] amt;
  logic             accept, ser_load, ser_last;
  logic [DATA_W-1:0] ser_next, bar_sel;
  logic [DATA_W-1:0] bar_out [NKIND];

  assign kind = op_e'(op_kind);

  always_comb begin
    unique case (kind)
      OP_LSH:  cur_impl = LSH_IMPL;
      OP_ASH:  cur_impl = ASH_IMPL;
      OP_ROT:  cur_impl = ROT_IMPL;
      default: cur_impl = IMPL_NONE;
    endcase
  end

  shift_amt_sel #(.W(DATA_W), .AMT_W(AMT_W)) u_amt (
    .from_imm(amt_from_imm), .imm(imm_amt), .reg_val(reg_amt), .amt(amt)
  );

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    if (IMPLS[k] == IMPL_BARREL) begin : g_bar
      shift_barrel #(.W(DATA_W), .KIND(op_e'(k)), .AMT_W(AMT_W)) u_bar (
        .din(operand), .amt(amt), .left(dir_left), .dout(bar_out[k])
      );
    end else begin : g_nobar
      assign bar_out[k] = '0;
    end
  end

  always_comb begin
    unique case (kind)
      OP_LSH:  bar_sel = bar_out[0];
      OP_ASH:  bar_sel = bar_out[1];
      OP_ROT:  bar_sel = bar_out[2];
      default: bar_sel = '0;
    endcase
  end

  assign accept   = start && !busy;
  assign ser_load = accept && (cur_impl == IMPL_SERIAL) && (amt != '0);

  shift_serial #(.W(DATA_W), .AMT_W(AMT_W)) u_ser (
    .clk(clk), .rst(rst), .load(ser_load), .load_kind(kind), .load_left(dir_left),
    .load_data(operand), .load_amt(amt), .busy(busy), .last(ser_last), .next_data(ser_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
      unimpl <= 1'b0;
    end else begin
      done   <= 1'b0;
      unimpl <= 1'b0;
      if (accept) begin
        unique case (cur_impl)
          IMPL_BARREL: begin result <= bar_sel; done <= 1'b1; end
          IMPL_SERIAL: if (amt == '0) begin result <= operand; done <= 1'b1; end
          default:     unimpl <= 1'b1;
        endcase
      end
      if (ser_last) begin
        result <= ser_next;
        done   <= 1'b1;
      end
    end
  end

  // R8: completion and unimplemented flags are exclusive.
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst) !(done && unimpl));
  // R6: flagging an unbuilt kind leaves the result alone.
  a_r6_hold: assert property (@(posedge clk) disable iff (rst) unimpl |-> $stable(result));
  // R3: a barrel kind answers on the next edge without going busy.
  a_r3_single: assert property (@(posedge clk) disable iff (rst)
    (accept && cur_impl == IMPL_BARREL) |=> (done && !busy));
  // R5: zero distance on a serial kind completes at once.
  a_r5_zero: assert property (@(posedge clk) disable iff (rst)
    (accept && cur_impl == IMPL_SERIAL && amt == '0) |=> (done && !busy));
  // R4: a nonzero serial request raises busy.
  a_r4_busy: assert property (@(posedge clk) disable iff (rst) ser_load |=> busy);
endmodule

// File: tb/shift_unit_test.sv
module shift_unit_test;
  import shift_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        start, dir_left, amt_from_imm;
  logic [1:0]  op_kind;
  logic [4:0]  imm_amt;
  logic [31:0] reg_amt, operand;
  logic [31:0] res_a, res_b;
  logic        busy_a, busy_b, done_a, done_b, unimpl_a, unimpl_b;
  int          total = 0, bad = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  shift_unit #(.LSH_IMPL(IMPL_BARREL), .ASH_IMPL(IMPL_SERIAL), .ROT_IMPL(IMPL_SERIAL)) uut (
    .clk(clk), .rst(rst), .start(start), .op_kind(op_kind), .dir_left(dir_left),
    .amt_from_imm(amt_from_imm), .imm_amt(imm_amt), .reg_amt(reg_amt), .operand(operand),
    .result(res_a), .busy(busy_a), .done(done_a), .unimpl(unimpl_a));

  shift_unit #(.LSH_IMPL(IMPL_SERIAL), .ASH_IMPL(IMPL_NONE), .ROT_IMPL(IMPL_BARREL)) uut_alt (
    .clk(clk), .rst(rst), .start(start), .op_kind(op_kind), .dir_left(dir_left),
    .amt_from_imm(amt_from_imm), .imm_amt(imm_amt), .reg_amt(reg_amt), .operand(operand),
    .result(res_b), .busy(busy_b), .done(done_b), .unimpl(unimpl_b));

  function automatic int impl_of(int u, int k);
    if (k == 3) return 0;
    if (u == 0) return (k == 0) ? 2 : 1;
    return (k == 0) ? 1 : (k == 1) ? 0 : 2;
  endfunction

  function automatic logic [31:0] model(int k, logic l, logic [31:0] d, int n);
    logic [31:0] x = d;
    for (int i = 0; i < n; i++) begin
      if (k == 2)      x = l ? {x[30:0], x[31]} : {x[0], x[31:1]};
      else if (k == 1) x = l ? {x[30:0], 1'b0} : {x[31], x[31:1]};
      else             x = l ? {x[30:0], 1'b0} : {1'b0, x[31:1]};
    end
    return x;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_op(int k, logic l, logic ui, logic [4:0] im, logic [31:0] ra,
                       logic [31:0] d, bit poke);
    logic [31:0] prev [2];
    int first [2], nd [2], nu [2], n, im_c;
    bit b0 [2];
    prev[0] = res_a; prev[1] = res_b;
    n = ui ? int'(im) : int'(ra[4:0]);   // R2
    @(negedge clk);
    op_kind = 2'(k); dir_left = l; amt_from_imm = ui; imm_amt = im; reg_amt = ra;
    operand = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int u = 0; u < 2; u++) begin first[u] = -1; nd[u] = 0; nu[u] = 0; end
    b0[0] = busy_a; b0[1] = busy_b;
    for (int c = 0; c < 40; c++) begin
      if (c > 0) @(negedge clk);
      if (poke && c == 2) begin operand = ~d; imm_amt = 5'd1; reg_amt = 32'd1; start = 1'b1; end
      if (poke && c == 3) start = 1'b0;
      if (done_a && unimpl_a) chk(0, "R8 uut both", 32'd1, 32'd0);
      if (done_b && unimpl_b) chk(0, "R8 uut_alt both", 32'd1, 32'd0);
      if ((done_a || unimpl_a) && first[0] < 0) first[0] = c;
      if ((done_b || unimpl_b) && first[1] < 0) first[1] = c;
      nd[0] += int'(done_a); nu[0] += int'(unimpl_a);
      nd[1] += int'(done_b); nu[1] += int'(unimpl_b);
    end
    for (int u = 0; u < 2; u++) begin
      int im_k = impl_of(u, k);
      logic [31:0] r = (u == 0) ? res_a : res_b;
      int lat = (im_k == 1) ? n : 0;
      if (poke && u == 1) continue;
      im_c = im_k;
      chk(first[u] == lat, im_c == 0 ? "R6 latency" : im_c == 2 ? "R3 latency" :
          (n == 0 ? "R5 latency" : "R4 latency"), 32'(first[u]), 32'(lat));
      if (im_k == 0) begin
        chk(nu[u] == 1 && nd[u] == 0, "R8 R6 pulse count", 32'(nu[u] * 16 + nd[u]), 32'h10);
        chk(r == prev[u], "R6 result held", r, prev[u]);
      end else begin
        chk(nd[u] == 1 && nu[u] == 0, "R8 done pulse count", 32'(nd[u] * 16 + nu[u]), 32'h10);
        chk(r == model(k, l, d, (im_k == 1 || im_k == 2) ? n : 0),
            poke ? "R7 result" : "R1 R2 result", r, model(k, l, d, n));
      end
      chk(b0[u] == (im_k == 1 && n > 0), "R4 busy after accept", 32'(b0[u]),
          32'(im_k == 1 && n > 0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R9 watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0; op_kind = 2'd0; dir_left = 1'b0; amt_from_imm = 1'b0;
    imm_amt = '0; reg_amt = '0; operand = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(res_a == 0 && res_b == 0, "R9 result", res_a | res_b, 32'd0);
    chk(!(busy_a | busy_b | done_a | done_b | unimpl_a | unimpl_b), "R9 flags",
        {26'd0, busy_a, busy_b, done_a, done_b, unimpl_a, unimpl_b}, 32'd0);
    // Directed corners
    do_op(1, 1'b0, 1'b1, 5'd31, 32'd0, 32'h8000_0001, 0);   // R1 sign fill, max distance
    do_op(0, 1'b0, 1'b1, 5'd4,  32'd0, 32'hF000_000F, 0);   // R1 zero fill
    do_op(2, 1'b1, 1'b1, 5'd8,  32'd0, 32'h1234_5678, 0);   // R1 rotate wrap
    do_op(2, 1'b0, 1'b0, 5'd0,  32'hFFFF_FFE3, 32'hA5A5_0F0F, 0); // R2 upper bits ignored
    do_op(1, 1'b1, 1'b1, 5'd0,  32'd0, 32'hDEAD_BEEF, 0);   // R5 zero distance
    do_op(0, 1'b1, 1'b0, 5'd9,  32'd0, 32'hCAFE_F00D, 0);   // R5 zero via register
    do_op(3, 1'b1, 1'b1, 5'd3,  32'd0, 32'h1111_1111, 0);   // R6 reserved kind
    do_op(1, 1'b0, 1'b1, 5'd20, 32'd0, 32'h9000_0003, 1);   // R7 start while busy
    repeat (40) @(negedge clk);
    // Random mix
    for (int i = 0; i < 70; i++)
      do_op(int'($urandom % 4), 1'($urandom), 1'($urandom), 5'($urandom),
            $urandom, $urandom, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule